// File: doc/BRIEF.md
# Playback Sample Concealment Interpolator

This block sits in the playback path between the error corrector and the converter output stage. Samples arrive as a valid/ready stream. Each sample carries a channel tag and a flag that marks it as uncorrectable. The block holds one sample per channel in a lookahead slot. When the next sample of the same channel arrives, the slot's occupant is resolved and sent downstream. A good sample passes through unchanged. A flagged sample whose successor is good is replaced by the midpoint of the last value the channel emitted and that successor. A flagged sample whose successor is also flagged is replaced by the last emitted value of the channel.

Each output sample comes with a registered concealment indicator. The indicator is high exactly when that sample was synthesized rather than passed through. Interleaved channels, such as left and right, each keep their own lookahead slot and history. They never borrow values from one another.

Top module: `sample_conceal`

## Requirements
- R1: After synchronous reset, `out_valid` and `conceal_flag` are 0. `in_ready` is 1. No channel has a pending sample. Every channel's history value is 0.
- R2: The first sample accepted on a channel produces no output. Each later sample accepted on that channel releases the channel's pending sample in the next cycle. Samples leave in the order in which they are released.
- R3: A pending sample whose error flag is 0 is emitted unchanged, with `conceal_flag` = 0.
- R4: A flagged pending sample whose successor is unflagged is emitted as (history + successor) >>> 1, with `conceal_flag` = 1. The sum is formed in 17-bit two's complement, and the result rounds toward negative infinity. History is the last value emitted on that channel.
- R5: A flagged pending sample whose successor is also flagged is emitted as the channel's history value, with `conceal_flag` = 1.
- R6: `in_chan` (0 to NUM_CH-1) selects the slot and history that are used. `out_chan` carries the tag of the emitted sample.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output data, tag and flag hold steady. `in_ready` equals `!out_valid || out_ready`.
- R8: `conceal_flag` is never high without `out_valid`, and it belongs to the sample it accompanies.
- R9: The midpoint never overflows. Two samples of 32767 give 32767, two samples of -32768 give -32768, and -1 with 0 gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be taken |
| in_data | input | 16 | Input sample, two's complement |
| in_err | input | 1 | Input sample is uncorrectable |
| in_chan | input | 1 | Input channel tag |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | 16 | Output sample |
| out_chan | output | 1 | Output channel tag |
| conceal_flag | output | 1 | Output sample was synthesized |

## Verification
A wrong history value stays invisible while samples are good. It appears on the first concealed sample of that channel, which can be many samples later. The bench therefore conceals repeatedly on each channel and runs hold chains, so every history update is observed. A slot kept under the wrong channel shows at once as a tag or value mismatch on the next release, because the two channels are interleaved. Midpoint rounding and overflow errors appear on the specific extreme samples driven for R9. Handshake errors appear as duplicated or lost samples in the scoreboard, and the bench exposes them by applying backpressure throughout the run.

// File: rtl/sample_conceal_pkg.sv
package sample_conceal_pkg;
  typedef enum logic [1:0] {
    RES_PASS   = 2'd0,
    RES_MID    = 2'd1,
    RES_HOLD   = 2'd2
  } res_kind_e;
endpackage

// File: rtl/sc_slot_store.sv
module sc_slot_store #(
  parameter int W   = 16,
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [CW-1:0] rd_ch,
  output logic         rd_pend,
  output logic [W-1:0] rd_data,
  output logic         rd_err,
  output logic [W-1:0] rd_hist,
  input  logic         slot_we,
  input  logic [CW-1:0] wr_ch,
  input  logic [W-1:0] wr_data,
  input  logic         wr_err,
  input  logic         hist_we,
  input  logic [W-1:0] hist_val
);
  logic [W-1:0] slot_mem [NCH];
  logic         slot_err [NCH];
  logic         slot_pend [NCH];
  logic [W-1:0] hist_mem [NCH];

  always_ff @(posedge clk) begin
    if (slot_we) begin
      slot_mem[wr_ch] <= wr_data;
      slot_err[wr_ch] <= wr_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        slot_pend[i] <= 1'b0;
        hist_mem[i]  <= '0;
      end
    end else begin
      if (slot_we) slot_pend[wr_ch] <= 1'b1;
      if (hist_we) hist_mem[wr_ch]  <= hist_val;
    end
  end

  assign rd_pend = slot_pend[rd_ch];
  assign rd_data = slot_mem[rd_ch];
  assign rd_err  = slot_err[rd_ch];
  assign rd_hist = hist_mem[rd_ch];
endmodule

// File: rtl/sc_resolve.sv
module sc_resolve
  import sample_conceal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] pend_data,
  input  logic         pend_err,
  input  logic [W-1:0] hist,
  input  logic [W-1:0] next_data,
  input  logic         next_err,
  output logic [W-1:0] res_data,
  output logic         res_conceal,
  output res_kind_e    res_kind
);
  localparam int SW = W + 1;
  logic signed [SW-1:0] sum_ext;

  assign sum_ext = $signed({hist[W-1], hist}) + $signed({next_data[W-1], next_data});

  always_comb begin
    if (!pend_err)     res_kind = RES_PASS;
    else if (!next_err) res_kind = RES_MID;
    else               res_kind = RES_HOLD;
    unique case (res_kind)
      RES_MID:  res_data = sum_ext[SW-1:1];
      RES_HOLD: res_data = hist;
      default:  res_data = pend_data;
    endcase
    res_conceal = (res_kind != RES_PASS);
  end
endmodule

// File: rtl/sample_conceal.sv
module sample_conceal
  import sample_conceal_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          in_err,
  input  logic [CW-1:0] in_chan,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] out_chan,
  output logic          conceal_flag
);
  logic         accept;
  logic         release_now;
  logic         rd_pend;
  logic [W-1:0] rd_data;
  logic         rd_err;
  logic [W-1:0] rd_hist;
  logic [W-1:0] res_data;
  logic         res_conceal;
  res_kind_e    res_kind;

  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign release_now = accept && rd_pend;

  sc_slot_store #(.W(W), .NCH(NCH), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_ch    (in_chan),
    .rd_pend  (rd_pend),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .rd_hist  (rd_hist),
    .slot_we  (accept),
    .wr_ch    (in_chan),
    .wr_data  (in_data),
    .wr_err   (in_err),
    .hist_we  (release_now),
    .hist_val (res_data)
  );

  sc_resolve #(.W(W)) u_resolve (
    .pend_data   (rd_data),
    .pend_err    (rd_err),
    .hist        (rd_hist),
    .next_data   (in_data),
    .next_err    (in_err),
    .res_data    (res_data),
    .res_conceal (res_conceal),
    .res_kind    (res_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_chan     <= '0;
      conceal_flag <= 1'b0;
    end else if (release_now) begin
      out_valid    <= 1'b1;
      out_data     <= res_data;
      out_chan     <= in_chan;
      conceal_flag <= res_conceal;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
      conceal_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_conceal_chk.sv
module sample_conceal_chk #(
  parameter int W   = 16,
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic [CW-1:0] out_chan,
  input logic          conceal_flag
);
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan) && $stable(conceal_flag)));

  p_ready_when_empty_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_flag_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    conceal_flag |-> out_valid);

  p_rise_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_chan_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_chan) < NCH));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !conceal_flag));
endmodule

bind sample_conceal sample_conceal_chk #(.W(W), .NCH(NCH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_chan     (out_chan),
  .conceal_flag (conceal_flag)
);

// File: tb/sample_conceal_bench.sv
`timescale 1ns/1ps
module sample_conceal_bench;
  localparam int W = 16;
  localparam int NCH = 2;
  localparam int CW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic in_err = 1'b0;
  logic [CW-1:0] in_chan = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic [CW-1:0] out_chan;
  logic conceal_flag;

  always #2.5 clk = ~clk;

  sample_conceal #(.W(W), .NCH(NCH)) u_sample_conceal (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_err(in_err), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .conceal_flag(conceal_flag)
  );

  typedef struct {
    logic [CW-1:0] ch;
    logic [W-1:0]  d;
    logic          f;
    string         req;
  } exp_t;

  exp_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R3";
  bit bp_on = 1'b0;
  bit done = 1'b0;

  logic          m_pend [NCH];
  logic [W-1:0]  m_data [NCH];
  logic          m_err  [NCH];
  logic [W-1:0]  m_hist [NCH];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mid(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] s;
    s = $signed({a[W-1], a}) + $signed({b[W-1], b});
    return s[W:1];
  endfunction

  task automatic model_accept(input logic [CW-1:0] ch, input logic [W-1:0] d, input logic e);
    exp_t x;
    if (m_pend[ch]) begin
      x.ch = ch;
      x.req = cur_req;
      if (!m_err[ch]) begin x.d = m_data[ch]; x.f = 1'b0; end
      else if (!e)   begin x.d = mid(m_hist[ch], d); x.f = 1'b1; end
      else           begin x.d = m_hist[ch]; x.f = 1'b1; end
      m_hist[ch] = x.d;
      sb_q.push_back(x);
    end
    m_pend[ch] = 1'b1;
    m_data[ch] = d;
    m_err[ch]  = e;
  endtask

  task automatic send(input logic [CW-1:0] ch, input int v, input logic e);
    bit taken;
    @(negedge clk);
    in_valid = 1'b1;
    in_chan  = ch;
    in_data  = v[W-1:0];
    in_err   = e;
    taken = 1'b0;
    while (!taken) begin
      #1;
      taken = in_ready;
      @(posedge clk);
      if (!taken) @(negedge clk);
    end
    model_accept(ch, v[W-1:0], e);
    #0.5;
    in_valid = 1'b0;
  endtask

  // backpressure pattern driven at falling edges
  int bp_cnt = 0;
  always @(negedge clk) begin
    bp_cnt <= bp_cnt + 1;
    out_ready <= bp_on ? ((bp_cnt % 5) < 3) : 1'b1;
  end

  // monitor / scoreboard
  bit           held = 1'b0;
  logic [W-1:0] held_d;
  logic         held_f;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst) continue;
      if (held) begin
        check(out_valid && out_data == held_d && conceal_flag == held_f, "R7",
              "stalled output changed", longint'($signed(out_data)), longint'($signed(held_d)));
        held = 1'b0;
      end
      if (conceal_flag && !out_valid)
        check(1'b0, "R8", "flag without valid", 1, 0);
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected output", longint'($signed(out_data)), 0);
        end else begin
          exp_t x;
          x = sb_q.pop_front();
          check(out_chan == x.ch, "R6", "channel tag", out_chan, x.ch);
          check(out_data == x.d, x.req, "sample value",
                longint'($signed(out_data)), longint'($signed(x.d)));
          check(conceal_flag == x.f, "R8", "conceal flag", conceal_flag, x.f);
        end
      end else if (out_valid && !out_ready) begin
        held = 1'b1; held_d = out_data; held_f = conceal_flag;
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_pend[i] = 1'b0; m_data[i] = '0; m_err[i] = 1'b0; m_hist[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(!conceal_flag, "R1", "conceal_flag after reset", conceal_flag, 0);
    check(in_ready, "R1", "in_ready after reset", in_ready, 1);

    // R1/R4: first sample of channel 1 flagged, history is zero
    cur_req = "R1"; send(1, 40, 1);
    cur_req = "R4"; send(1, 60, 0);       // releases mid(0,60)=30

    // R2: first sample on channel 0 yields nothing
    cur_req = "R3"; send(0, 100, 0);
    repeat (3) @(negedge clk);
    #1.5;
    check(sb_q.size() == 0 && !out_valid, "R2", "first channel-0 sample emitted", out_valid, 0);

    cur_req = "R4"; send(0, 200, 1);      // releases 100 (pass)
    send(0, 300, 0);                      // releases mid(100,300)=200
    cur_req = "R3"; send(0, 7, 1);        // releases 300 pass
    cur_req = "R5"; send(0, 9, 1);        // releases hold 300
    cur_req = "R4"; send(0, -5, 0);       // releases mid(300,-5)=147

    // R6: interleaved channels
    cur_req = "R6";
    send(0, 1000, 0); send(1, -2000, 1); send(0, 1200, 1); send(1, -1000, 0);
    send(0, 1400, 0); send(1, 500, 0);

    // R7: backpressure with mixed traffic
    bp_on = 1'b1;
    cur_req = "R7";
    for (int k = 0; k < 40; k++)
      send(k[0], (k * 1237) - 20000, (k % 7) == 3 || (k % 11) == 4);
    bp_on = 1'b0;

    // R9: extremes
    cur_req = "R9";
    send(0, 32767, 0); send(0, 0, 1); send(0, 32767, 0);   // mid = 32767
    send(1, -32768, 0); send(1, 0, 1); send(1, -32768, 0); // mid = -32768
    send(0, -1, 0); send(0, 0, 1); send(0, 0, 0);          // mid(-1,0) = -1
    send(0, 5, 0);                                         // flush before

    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R2", "scoreboard left over", sb_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule